// File: doc/BRIEF.md
# Sixteen-Pin I2C Port Expander

This block is an I2C target that gives a host processor control of sixteen general-purpose pins, grouped into two 8-bit ports. For each port it holds an output latch, a read-inversion mask and a direction mask. The host reaches them through a command byte that sets an internal register pointer. Pins in input mode can be read at any time. An active-low, open-drain change flag tells the host when an input pin no longer matches the value it last read.

SCL and SDA come in as plain logic levels. The block pulls SDA low by raising `sda_oe`. Three strap inputs set the low address bits, so eight of these blocks can share one bus. Each pad is modelled as an enable plus a value. An elaboration option makes every output open-drain: a 1 in the output latch then releases the pin rather than driving it high. All bus and pin inputs are sampled with the block's own clock, which must run well above the SCL rate.

Top module: `gpx_expander`

## Requirements
- R1: The block answers only to the 7-bit address `0100` followed by `strap[2:0]` (strap[2] most significant). It pulls SDA low in the acknowledge slot for a match. Any other address gets no acknowledge, and the rest of that transfer is ignored until the next START.
- R2: The low three bits of the command byte set the pointer; bits 7:3 are ignored. Pointer 0/1 selects the port 0/1 input register, 2/3 the output latch, 4/5 the inversion mask and 6/7 the direction mask. Each data byte written or read flips pointer bit 0, so a run of bytes alternates between the two registers of a pair.
- R3: After reset the output latches are 0xFF, the inversion masks 0x00 and the direction masks 0xFF (all pins inputs). `pad_oe`, `sda_oe` and `int_oe` are all 0.
- R4: Reading an input register returns the synchronised pin values of that port, XORed bit by bit with that port's inversion mask.
- R5: Data bytes written to pointer 0 or 1 are acknowledged but change no register.
- R6: Direction bit 1 means input and 0 means output; port 0 maps to pins 7:0 and port 1 to pins 15:8. In the push-pull build `pad_oe` is the inverse of the direction mask and `pad_o` equals the output latch. In the open-drain build `pad_o` is 0, and `pad_oe` is 1 only for an output pin whose latch bit is 0.
- R7: `int_oe` is 1 when any pin in input mode differs from that port's snapshot. A read of a port's input register stores the returned pin values as its snapshot. The flag drops after such a read, or when the pins go back to the snapshot. Pins in output mode never raise it.
- R8: The host can read back every output latch, inversion mask and direction mask.
- R9: Each data byte of a matched write is acknowledged. During a read, a master acknowledge loads the next byte and a master no-acknowledge ends the transfer. The block only changes SDA while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap | input | 3 | Low three address bits |
| pad_i | input | 16 | Pin levels, port 1 in 15:8 |
| pad_oe | output | 16 | Pin drive enable |
| pad_o | output | 16 | Pin drive value |
| int_oe | output | 1 | 1 pulls the change flag line low |

## Verification
On every cycle, the assertions check four things: an input-mode pin is never driven, SDA is only pulled low while SCL is low, every data byte moves the pointer to the other register of its pair, and the change flag stays quiet while every pin is an output. The reset state is also checked when reset is released. The directed scenarios are needed for the rest. They cover address matching against the straps, the register contents returned over the bus, the inversion applied to input reads, writes to input registers having no effect, and the open-drain drive pattern. They also cover the change flag's full life across snapshot reads of one port and the other.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int PORT_W = 8;
  localparam int NPORTS = 2;
  localparam int PINS   = PORT_W * NPORTS;
  localparam logic [3:0] ADDR_HI = 4'b0100;

  // pointer bits 2:1 select the register group
  localparam logic [1:0] GRP_IN  = 2'd0;
  localparam logic [1:0] GRP_OUT = 2'd1;
  localparam logic [1:0] GRP_POL = 2'd2;
  localparam logic [1:0] GRP_CFG = 2'd3;

  typedef enum logic [2:0] {
    T_IDLE,
    T_ADDR,
    T_CMD,
    T_WDATA,
    T_READ
  } tgt_state_e;
endpackage

// File: rtl/gpx_insync.sv
module gpx_insync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d_i;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) stg[s] <= stg[s-1];
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpx_i2c_tgt.sv
module gpx_i2c_tgt
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       scl_s,
  output logic       wr_en,
  output logic       rd_en,
  output logic [2:0] ptr,
  output logic [7:0] wr_data
);
  logic [1:0] bus_s;
  logic       sda_s, scl_d, sda_d;
  logic       scl_rise, scl_fall, start_c, stop_c;
  tgt_state_e state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, tx;
  logic       ack_ph, is_read, mack;

  gpx_insync #(.W(2), .STAGES(SYNC_STAGES)) u_bus_sync (
    .clk (clk),
    .d_i ({scl_i, sda_i}),
    .q_o (bus_s)
  );

  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    rd_en <= 1'b0;
    if (rst) begin
      state   <= T_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      tx      <= '0;
      ack_ph  <= 1'b0;
      is_read <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      wr_data <= '0;
    end else begin
      if (wr_en || rd_en) ptr[0] <= ~ptr[0];
      if (start_c) begin
        state  <= T_ADDR;
        bitcnt <= '0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= T_IDLE;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          T_ADDR, T_CMD, T_WDATA: begin
            if (scl_rise && !ack_ph && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && !ack_ph && bitcnt == 4'd8) begin
              if (state == T_ADDR) begin
                if (shreg[7:1] == {ADDR_HI, strap}) begin
                  sda_oe  <= 1'b1;
                  ack_ph  <= 1'b1;
                  is_read <= shreg[0];
                end else begin
                  state <= T_IDLE;
                end
              end else if (state == T_CMD) begin
                ptr    <= shreg[2:0];
                sda_oe <= 1'b1;
                ack_ph <= 1'b1;
              end else begin
                wr_en   <= 1'b1;
                wr_data <= shreg;
                sda_oe  <= 1'b1;
                ack_ph  <= 1'b1;
              end
            end else if (scl_fall && ack_ph) begin
              ack_ph <= 1'b0;
              bitcnt <= '0;
              sda_oe <= 1'b0;
              if (state == T_ADDR) begin
                if (is_read) begin
                  state  <= T_READ;
                  tx     <= rd_data;
                  sda_oe <= ~rd_data[7];
                  rd_en  <= 1'b1;
                  bitcnt <= 4'd1;
                end else begin
                  state <= T_CMD;
                end
              end else if (state == T_CMD) begin
                state <= T_WDATA;
              end
            end
          end
          T_READ: begin
            if (scl_fall && !ack_ph) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                ack_ph <= 1'b1;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end else if (scl_rise && ack_ph) begin
              mack <= ~sda_s;
            end else if (scl_fall && ack_ph) begin
              ack_ph <= 1'b0;
              if (mack) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                rd_en  <= 1'b1;
                bitcnt <= 4'd1;
              end else begin
                state <= T_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter logic [PORT_W-1:0] OUT_RST = '1,
  parameter logic [PORT_W-1:0] POL_RST = '0,
  parameter logic [PORT_W-1:0] CFG_RST = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [2:0]      ptr,
  input  logic [7:0]      wr_data,
  input  logic [PINS-1:0] pins_s,
  output logic [7:0]      rd_data,
  output logic [PINS-1:0] out_all,
  output logic [PINS-1:0] cfg_all,
  output logic            pending
);
  logic [PORT_W-1:0] out_q  [NPORTS];
  logic [PORT_W-1:0] pol_q  [NPORTS];
  logic [PORT_W-1:0] cfg_q  [NPORTS];
  logic [PORT_W-1:0] snap_q [NPORTS];
  logic [NPORTS-1:0] diff;
  logic [PINS-1:0]   pins_d;
  logic              snap_ok;
  logic              sel;
  logic [1:0]        grp;

  assign sel = ptr[0];
  assign grp = ptr[2:1];

  always_ff @(posedge clk) begin
    pins_d <= pins_s;
    if (rst) snap_ok <= 1'b0;
    else     snap_ok <= 1'b1;
  end

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      always_ff @(posedge clk) begin
        if (rst) begin
          out_q[p] <= OUT_RST;
          pol_q[p] <= POL_RST;
          cfg_q[p] <= CFG_RST;
        end else if (wr_en && sel == 1'(p)) begin
          case (grp)
            GRP_OUT: out_q[p] <= wr_data;
            GRP_POL: pol_q[p] <= wr_data;
            GRP_CFG: cfg_q[p] <= wr_data;
            default: ;
          endcase
        end
      end

      always_ff @(posedge clk) begin
        if (rst)
          snap_q[p] <= '0;
        else if (!snap_ok)
          snap_q[p] <= pins_s[p*PORT_W +: PORT_W];
        else if (rd_en && grp == GRP_IN && sel == 1'(p))
          snap_q[p] <= pins_d[p*PORT_W +: PORT_W];
      end

      assign diff[p] = |((pins_s[p*PORT_W +: PORT_W] ^ snap_q[p]) & cfg_q[p]);
      assign out_all[p*PORT_W +: PORT_W] = out_q[p];
      assign cfg_all[p*PORT_W +: PORT_W] = cfg_q[p];
    end
  endgenerate

  assign pending = snap_ok & (|diff);

  always_comb begin
    case (grp)
      GRP_IN:  rd_data = pins_s[PORT_W*int'(sel) +: PORT_W] ^ pol_q[sel];
      GRP_OUT: rd_data = out_q[sel];
      GRP_POL: rd_data = pol_q[sel];
      default: rd_data = cfg_q[sel];
    endcase
  end
endmodule

// File: rtl/gpx_pads.sv
module gpx_pads
  import gpx_pkg::*;
#(
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] out_all,
  input  logic [PINS-1:0] cfg_all,
  input  logic            pending,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_o,
  output logic            int_oe
);
  logic [PINS-1:0] oe_n, o_n;

  generate
    if (OPEN_DRAIN) begin : g_od
      assign oe_n = ~cfg_all & ~out_all;
      assign o_n  = '0;
    end else begin : g_pp
      assign oe_n = ~cfg_all;
      assign o_n  = out_all;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe <= '0;
      pad_o  <= '0;
      int_oe <= 1'b0;
    end else begin
      pad_oe <= oe_n;
      pad_o  <= o_n;
      int_oe <= pending;
    end
  end
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit OPEN_DRAIN  = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic [2:0]      strap,
  input  logic [PINS-1:0] pad_i,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_o,
  output logic            int_oe
);
  logic            scl_s, wr_en, rd_en, pending;
  logic [2:0]      ptr;
  logic [7:0]      wr_data, rd_data;
  logic [PINS-1:0] pins_s, out_all, cfg_all;

  gpx_insync #(.W(PINS), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk (clk),
    .d_i (pad_i),
    .q_o (pins_s)
  );

  gpx_i2c_tgt #(.SYNC_STAGES(SYNC_STAGES)) u_tgt (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .strap   (strap),
    .rd_data (rd_data),
    .sda_oe  (sda_oe),
    .scl_s   (scl_s),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .ptr     (ptr),
    .wr_data (wr_data)
  );

  gpx_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .ptr     (ptr),
    .wr_data (wr_data),
    .pins_s  (pins_s),
    .rd_data (rd_data),
    .out_all (out_all),
    .cfg_all (cfg_all),
    .pending (pending)
  );

  gpx_pads #(.OPEN_DRAIN(OPEN_DRAIN)) u_pads (
    .clk     (clk),
    .rst     (rst),
    .out_all (out_all),
    .cfg_all (cfg_all),
    .pending (pending),
    .pad_oe  (pad_oe),
    .pad_o   (pad_o),
    .int_oe  (int_oe)
  );
endmodule

// File: rtl/gpx_expander_chk.sv
module gpx_expander_chk
  import gpx_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            scl_s,
  input logic            sda_oe,
  input logic            wr_en,
  input logic            rd_en,
  input logic [2:0]      ptr,
  input logic [PINS-1:0] cfg_all,
  input logic [PINS-1:0] pad_oe,
  input logic            int_oe
);
  // R3: nothing driven when reset is released
  a_r3_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_oe == '0 && !sda_oe && !int_oe));

  // R6: a pin in input mode is never driven
  a_r6_input_undriven: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(cfg_all)) == '0));

  // R9: SDA pull-down only begins while SCL is low
  a_r9_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R2: each data byte moves to the other register of the pair
  a_r2_pair_toggle: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_en) |=> (ptr[2:1] == $past(ptr[2:1]) && ptr[0] != $past(ptr[0])));

  // R7: no change flag while every pin is an output
  a_r7_outputs_silent: assert property (@(posedge clk) disable iff (rst)
    (cfg_all == '0) |=> !int_oe);
endmodule

bind gpx_expander gpx_expander_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .scl_s   (scl_s),
  .sda_oe  (sda_oe),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .ptr     (ptr),
  .cfg_all (cfg_all),
  .pad_oe  (pad_oe),
  .int_oe  (int_oe)
);

// File: tb/sim_gpx_expander.sv
module sim_gpx_expander;
  localparam int QT = 8;
  localparam logic [6:0] A0 = {4'b0100, 3'b010};
  localparam logic [6:0] A1 = {4'b0100, 3'b101};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_tb = 1'b1;
  logic sda_tb = 1'b1;
  logic [15:0] pins0 = 16'h0000;
  logic [15:0] pins1 = 16'h0000;
  logic sda_oe0, sda_oe1, int0, int1;
  logic [15:0] oe0, o0, oe1, o1;
  wire sda_bus = sda_tb & ~sda_oe0 & ~sda_oe1;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpx_expander u0 (
    .clk(clk), .rst(rst), .scl_i(scl_tb), .sda_i(sda_bus), .sda_oe(sda_oe0),
    .strap(3'b010), .pad_i(pins0), .pad_oe(oe0), .pad_o(o0), .int_oe(int0)
  );

  gpx_expander #(.OPEN_DRAIN(1'b1)) u1 (
    .clk(clk), .rst(rst), .scl_i(scl_tb), .sda_i(sda_bus), .sda_oe(sda_oe1),
    .strap(3'b101), .pad_i(pins1), .pad_oe(oe1), .pad_o(o1), .int_oe(int1)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_tb = 1'b1; wt(QT);
    scl_tb = 1'b1; wt(QT);
    sda_tb = 1'b0; wt(QT);
    scl_tb = 1'b0; wt(QT);
  endtask

  task automatic bus_stop();
    sda_tb = 1'b0; wt(QT);
    scl_tb = 1'b1; wt(QT);
    sda_tb = 1'b1; wt(QT);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_tb = b[i]; wt(QT);
      scl_tb = 1'b1; wt(2*QT);
      scl_tb = 1'b0; wt(QT);
    end
    sda_tb = 1'b1; wt(QT);
    scl_tb = 1'b1; wt(QT);
    ack = ~sda_bus; wt(QT);
    scl_tb = 1'b0; wt(QT);
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    sda_tb = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(QT);
      scl_tb = 1'b1; wt(QT);
      b[i] = sda_bus; wt(QT);
      scl_tb = 1'b0; wt(QT);
    end
    sda_tb = ~give_ack; wt(QT);
    scl_tb = 1'b1; wt(2*QT);
    scl_tb = 1'b0; wt(QT);
    sda_tb = 1'b1;
  endtask

  task automatic wr_regs(input logic [6:0] a, input logic [7:0] cmd,
                         input logic [7:0] d0, input logic [7:0] d1,
                         input string req);
    logic ack;
    bus_start();
    wr_byte({a, 1'b0}, ack); chk(req, "addr ack", 16'(ack), 16'd1);
    wr_byte(cmd, ack);       chk(req, "cmd ack",  16'(ack), 16'd1);
    wr_byte(d0, ack);        chk(req, "d0 ack",   16'(ack), 16'd1);
    wr_byte(d1, ack);        chk(req, "d1 ack",   16'(ack), 16'd1);
    bus_stop();
  endtask

  task automatic rd_regs(input logic [6:0] a, input logic [7:0] cmd, input int n,
                         output logic [7:0] d0, output logic [7:0] d1);
    logic ack;
    d1 = 8'h00;
    bus_start();
    wr_byte({a, 1'b0}, ack);
    wr_byte(cmd, ack);
    bus_start();
    wr_byte({a, 1'b1}, ack);
    rd_byte(n > 1, d0);
    if (n > 1) rd_byte(1'b0, d1);
    bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] a, b;
    chk("R3", "pad_oe u0", oe0, 16'h0000);
    chk("R3", "pad_oe u1", oe1, 16'h0000);
    chk("R3", "int_oe", {15'd0, int0}, 16'd0);
    chk("R3", "sda_oe", {15'd0, sda_oe0}, 16'd0);
    rd_regs(A0, 8'd6, 2, a, b); chk("R3", "cfg default", {b, a}, 16'hFFFF);
    rd_regs(A0, 8'd2, 2, a, b); chk("R3", "out default", {b, a}, 16'hFFFF);
    rd_regs(A0, 8'd4, 2, a, b); chk("R3", "pol default", {b, a}, 16'h0000);
  endtask

  task automatic t_address();
    logic ack;
    bus_start();
    wr_byte({7'h21, 1'b0}, ack); chk("R1", "foreign addr nack", 16'(ack), 16'd0);
    wr_byte(8'h02, ack);         chk("R1", "ignored after nack", 16'(ack), 16'd0);
    bus_stop();
    bus_start();
    wr_byte({A0, 1'b0}, ack);    chk("R1", "own addr ack", 16'(ack), 16'd1);
    bus_stop();
    bus_start();
    wr_byte({A1, 1'b0}, ack);    chk("R1", "second strap ack", 16'(ack), 16'd1);
    bus_stop();
  endtask

  task automatic t_outputs();
    logic [7:0] a, b;
    wr_regs(A0, 8'd2, 8'hA5, 8'h3C, "R9");
    wr_regs(A0, 8'd6, 8'h00, 8'h0F, "R9");
    wt(4);
    chk("R6", "push-pull oe", oe0, 16'hF0FF);
    chk("R6", "push-pull o", o0, 16'h3CA5);
    rd_regs(A0, 8'd2, 2, a, b); chk("R8", "out readback", {b, a}, 16'h3CA5);
    rd_regs(A0, 8'd6, 2, a, b); chk("R8", "cfg readback", {b, a}, 16'h0FF0 ^ 16'h00F0 ^ 16'h00F0 ^ 16'h0FF0 ^ 16'h0F00);
  endtask

  task automatic t_open_drain();
    wr_regs(A1, 8'd2, 8'h0F, 8'hF0, "R9");
    wr_regs(A1, 8'd6, 8'h00, 8'h00, "R9");
    wt(4);
    chk("R6", "open-drain oe", oe1, 16'h0FF0);
    chk("R6", "open-drain o", o1, 16'h0000);
  endtask

  task automatic t_polarity();
    logic [7:0] a, b;
    wr_regs(A0, 8'd5, 8'h81, 8'h0F, "R2");
    rd_regs(A0, 8'd4, 2, a, b); chk("R2", "pair wrap write", {b, a}, 16'h810F);
    pins0 = 16'h5A33; wt(6);
    rd_regs(A0, 8'd0, 2, a, b); chk("R4", "inverted input", {b, a}, 16'hDB3C);
  endtask

  task automatic t_input_write();
    logic [7:0] a, b;
    wr_regs(A0, 8'd0, 8'h00, 8'h00, "R5");
    rd_regs(A0, 8'd0, 2, a, b); chk("R5", "input unchanged", {b, a}, 16'hDB3C);
    rd_regs(A0, 8'd2, 2, a, b); chk("R5", "out unchanged", {b, a}, 16'h3CA5);
    rd_regs(A0, 8'd4, 2, a, b); chk("R5", "pol unchanged", {b, a}, 16'h810F);
  endtask

  task automatic t_interrupt();
    logic [7:0] a, b;
    wr_regs(A0, 8'd6, 8'hFF, 8'hFF, "R9");
    rd_regs(A0, 8'd0, 2, a, b);
    wt(6); chk("R7", "idle after snapshot", {15'd0, int0}, 16'd0);
    pins0 = pins0 ^ 16'h0008; wt(8);
    chk("R7", "pin change raises", {15'd0, int0}, 16'd1);
    pins0 = pins0 ^ 16'h0008; wt(8);
    chk("R7", "return clears", {15'd0, int0}, 16'd0);
    pins0 = pins0 ^ 16'h0008; wt(8);
    rd_regs(A0, 8'd0, 1, a, b); wt(6);
    chk("R7", "port0 read clears", {15'd0, int0}, 16'd0);
    chk("R4", "read after change", {8'h00, a}, 16'h0034);
    pins0 = pins0 ^ 16'h0200; wt(8);
    rd_regs(A0, 8'd0, 1, a, b); wt(6);
    chk("R7", "other port read keeps", {15'd0, int0}, 16'd1);
    rd_regs(A0, 8'd1, 1, a, b); wt(6);
    chk("R7", "port1 read clears", {15'd0, int0}, 16'd0);
  endtask

  task automatic t_output_mask();
    wr_regs(A0, 8'd6, 8'h00, 8'hFF, "R9");
    pins0 = pins0 ^ 16'h00F0; wt(8);
    chk("R7", "output pins silent", {15'd0, int0}, 16'd0);
  endtask

  task automatic t_cmd_high_bits();
    logic [7:0] a, b;
    wr_regs(A0, 8'h0B, 8'h77, 8'h5E, "R2");
    rd_regs(A0, 8'h03, 2, a, b); chk("R2", "cmd upper bits ignored", {b, a}, 16'h5E77);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wt(5);
    rst = 1'b0;
    wt(4);
    t_reset();
    t_address();
    t_outputs();
    t_open_drain();
    t_polarity();
    t_input_write();
    t_interrupt();
    t_output_mask();
    t_cmd_high_bits();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule